// File: doc/BRIEF.md
# Condition Register Bit Logic Unit

This block holds a 32-bit condition register and executes the eight single-bit Boolean operations on it. Each instruction names two source bits and one destination bit by 5-bit index. The unit reads the two source bits, combines them with the function that the extended opcode selects, and writes the result into the destination bit. Every other bit of the register keeps its value.

An execution pipeline issues one decoded instruction word with a valid strobe. The register is updated on the next clock edge, and a one-cycle done pulse appears at the same time. A word that does not decode to one of the eight operations leaves the register unchanged and raises a one-cycle illegal flag instead. A load port writes the whole register for test setup, and the current register value is always visible on a read port.

Top module: `crbit_logic_unit`

## Requirements
- R1: With `rst_n` low at a rising clock edge, the register becomes all zeros and `done` and `illegal` become 0.
- R2: The instruction word is split as follows: bits [31:26] primary opcode, [25:21] destination index, [20:16] first source index A, [15:11] second source index B, [10:1] extended opcode, and bit [0] is ignored. Only primary opcode 19 is accepted. Bit index i refers to register bit 31-i, so index 0 is the most significant bit.
- R3: Extended opcode 257 writes A&B, 449 writes A|B, 193 writes A^B, and 225 writes ~(A&B).
- R4: Extended opcode 33 writes ~(A|B), 289 writes ~(A^B), 129 writes A&~B, and 417 writes A|~B.
- R5: A legal instruction changes no register bit other than the destination bit.
- R6: The destination may be the same bit as either source or both. The sources are always taken from the register value before the update.
- R7: When `insn_valid` is high at a clock edge, the register update and a `done` pulse take effect at that edge. `done` stays high for exactly one cycle for each instruction.
- R8: If the primary opcode is not 19, or the extended opcode is not one of the eight listed, the register keeps its value, `illegal` is high for one cycle, and `done` stays low.
- R9: When `load_en` is high at an edge, the register takes `load_value`. Any instruction presented in the same cycle is dropped, and neither `done` nor `illegal` is raised.
- R10: When neither `insn_valid` nor `load_en` is high, the register keeps its value and `done` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn_word | input | 32 | Decoded instruction word |
| load_en | input | 1 | Write the whole register from `load_value` |
| load_value | input | 32 | Value for a register load |
| cr_value | output | 32 | Current register contents |
| done | output | 1 | One-cycle pulse: a legal instruction has completed |
| illegal | output | 1 | One-cycle pulse: an instruction word was rejected |

## Verification
On every cycle the checker enforces the following rules. `done` and `illegal` are never high together. A completed instruction changes at most one register bit. A rejected instruction and an idle cycle change no bit. A load copies `load_value` exactly and raises no flag. Only the bench scenarios can show the behaviours that depend on the data. These are the truth table of each of the eight functions, the mapping from big-endian index to register bit, reading the sources before the write when the destination is one of them, and which opcodes count as illegal.

// File: rtl/crbl_pkg.sv
// Shared types and constants for the condition register bit logic unit.
// Assumes a 32-bit instruction word with the fixed field positions below.
package crbl_pkg;

    // Boolean function selected by the extended opcode
    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_NAND = 3'd3,
        OP_NOR  = 3'd4,
        OP_EQV  = 3'd5,
        OP_ANDC = 3'd6,
        OP_ORC  = 3'd7
    } crbl_op_e;

    // Instruction word fields, most significant first
    typedef struct packed {
        logic [5:0] prim;
        logic [4:0] dst;
        logic [4:0] srca;
        logic [4:0] srcb;
        logic [9:0] xo;
        logic       spare;
    } crbl_insn_t;

    localparam logic [9:0] XO_AND  = 10'd257;
    localparam logic [9:0] XO_OR   = 10'd449;
    localparam logic [9:0] XO_XOR  = 10'd193;
    localparam logic [9:0] XO_NAND = 10'd225;
    localparam logic [9:0] XO_NOR  = 10'd33;
    localparam logic [9:0] XO_EQV  = 10'd289;
    localparam logic [9:0] XO_ANDC = 10'd129;
    localparam logic [9:0] XO_ORC  = 10'd417;

endpackage

// File: rtl/crbl_decode.sv
// Decoder: maps primary and extended opcode to a Boolean function.
// Assumes the field layout of crbl_pkg. Pure combinational logic.
module crbl_decode
    import crbl_pkg::*;
#(
    parameter int PRIMARY = 19
) (
    input  crbl_insn_t insn,
    output crbl_op_e   op,
    output logic       legal
);

    // Look up the extended opcode and reject a wrong primary opcode
    always_comb begin
        op    = OP_AND;
        legal = (insn.prim == 6'(PRIMARY));
        case (insn.xo)
            XO_AND:  op = OP_AND;
            XO_OR:   op = OP_OR;
            XO_XOR:  op = OP_XOR;
            XO_NAND: op = OP_NAND;
            XO_NOR:  op = OP_NOR;
            XO_EQV:  op = OP_EQV;
            XO_ANDC: op = OP_ANDC;
            XO_ORC:  op = OP_ORC;
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/crbl_bitsel.sv
// Reads one bit of a vector by big-endian index (index 0 is the MSB).
// Assumes idx < W. An out-of-range index reads 0.
module crbl_bitsel #(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);

    // Mux the selected bit with an unrolled compare per position
    always_comb begin
        bit_o = 1'b0;
        for (int k = 0; k < W; k++) begin
            if (idx == IDX_W'(W - 1 - k)) bit_o = vec[k];
        end
    end

endmodule

// File: rtl/crbl_func.sv
// Applies the selected two-input Boolean function to a pair of bits.
module crbl_func
    import crbl_pkg::*;
(
    input  crbl_op_e op,
    input  logic     a,
    input  logic     b,
    output logic     y
);

    // One case arm per function
    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NAND: y = ~(a & b);
            OP_NOR:  y = ~(a | b);
            OP_EQV:  y = ~(a ^ b);
            OP_ANDC: y = a & ~b;
            default: y = a | ~b;
        endcase
    end

endmodule

// File: rtl/crbl_merge.sv
// Builds the next register value by replacing one big-endian indexed bit.
// When wr_en is low, the current value passes through unchanged.
module crbl_merge #(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     cur,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic             val,
    output logic [W-1:0]     nxt
);

    // Per-bit replace mux
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign nxt[g] = (wr_en && (idx == IDX_W'(W - 1 - g))) ? val : cur[g];
    end

endmodule

// File: rtl/crbit_logic_unit.sv
// Condition register bit logic unit: holds the register and executes
// single-bit logical operations. A load has priority over an instruction.
// Assumes a synchronous active-low reset.
module crbit_logic_unit
    import crbl_pkg::*;
#(
    parameter int CR_W    = 32,
    parameter int PRIMARY = 19
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_valid,
    input  logic [31:0]     insn_word,
    input  logic            load_en,
    input  logic [CR_W-1:0] load_value,
    output logic [CR_W-1:0] cr_value,
    output logic            done,
    output logic            illegal
);

    localparam int IDX_W = $clog2(CR_W);

    crbl_insn_t      insn;
    crbl_op_e        op;
    logic            legal;
    logic            bit_a;
    logic            bit_b;
    logic            result;
    logic            exec_ok;
    logic [CR_W-1:0] cr_q;
    logic [CR_W-1:0] cr_next;

    assign insn = crbl_insn_t'(insn_word);

    crbl_decode #(.PRIMARY(PRIMARY)) u_dec (
        .insn (insn),
        .op   (op),
        .legal(legal)
    );

    crbl_bitsel #(.W(CR_W), .IDX_W(IDX_W)) u_sel_a (
        .vec  (cr_q),
        .idx  (insn.srca[IDX_W-1:0]),
        .bit_o(bit_a)
    );

    crbl_bitsel #(.W(CR_W), .IDX_W(IDX_W)) u_sel_b (
        .vec  (cr_q),
        .idx  (insn.srcb[IDX_W-1:0]),
        .bit_o(bit_b)
    );

    crbl_func u_fn (
        .op(op),
        .a (bit_a),
        .b (bit_b),
        .y (result)
    );

    // A legal instruction only executes when no load competes
    assign exec_ok = insn_valid && legal && !load_en;

    crbl_merge #(.W(CR_W), .IDX_W(IDX_W)) u_merge (
        .cur  (cr_q),
        .wr_en(exec_ok),
        .idx  (insn.dst[IDX_W-1:0]),
        .val  (result),
        .nxt  (cr_next)
    );

    // Register update: reset, then load, then instruction result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q <= '0;
        end else if (load_en) begin
            cr_q <= load_value;
        end else begin
            cr_q <= cr_next;
        end
    end

    // Completion and rejection pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            done    <= exec_ok;
            illegal <= insn_valid && !legal && !load_en;
        end
    end

    assign cr_value = cr_q;

endmodule

// File: rtl/crbl_checker.sv
// Cycle-by-cycle property checker for crbit_logic_unit, attached by bind.
module crbl_checker #(
    parameter int CR_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            insn_valid,
    input logic            load_en,
    input logic [CR_W-1:0] load_value,
    input logic [CR_W-1:0] cr_value,
    input logic            done,
    input logic            illegal
);

    // done and illegal are exclusive (R8)
    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && illegal));

    // A rejected word leaves the register untouched (R8)
    p_illegal_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $stable(cr_value));

    // A completed instruction flips at most one bit (R5)
    p_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(cr_value ^ $past(cr_value)) <= 1));

    // done only follows a valid strobe (R7)
    p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(insn_valid));

    // A load copies the value and raises no flag (R9)
    p_load_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cr_value == $past(load_value)) && !done && !illegal);

    // Idle cycles hold the register (R10)
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!insn_valid && !load_en) |=> $stable(cr_value) && !done && !illegal);

endmodule

bind crbit_logic_unit crbl_checker #(.CR_W(CR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_valid(insn_valid),
    .load_en   (load_en),
    .load_value(load_value),
    .cr_value  (cr_value),
    .done      (done),
    .illegal   (illegal)
);

// File: tb/sim_crbit_logic_unit.sv
module sim_crbit_logic_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        load_en = 1'b0;
    logic [31:0] load_value = '0;
    logic [31:0] cr_value;
    logic        done;
    logic        illegal;

    int errors = 0;
    int checks = 0;
    logic [31:0] model = '0;

    always #5 clk = ~clk;

    crbit_logic_unit u0 (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .load_en(load_en), .load_value(load_value), .cr_value(cr_value),
        .done(done), .illegal(illegal)
    );

    function automatic logic [31:0] mk(input int prim, input int xo, input int d, input int a, input int b);
        return {6'(prim), 5'(d), 5'(a), 5'(b), 10'(xo), 1'b0};
    endfunction

    function automatic logic fn(input int xo, input logic a, input logic b);
        case (xo)
            257: return a & b;
            449: return a | b;
            193: return a ^ b;
            225: return ~(a & b);
            33:  return ~(a | b);
            289: return ~(a ^ b);
            129: return a & ~b;
            default: return a | ~b;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [31:0] v);
        @(negedge clk);
        load_en = 1'b1; load_value = v;
        @(negedge clk);
        load_en = 1'b0;
        model = v;
    endtask

    // Issue one legal op and check register, done, and the done drop
    task automatic run_op(input string req, input int xo, input int d, input int a, input int b);
        logic r;
        r = fn(xo, model[31-a], model[31-b]);
        model[31-d] = r;
        @(negedge clk);
        insn_valid = 1'b1; insn_word = mk(19, xo, d, a, b);
        @(negedge clk);
        insn_valid = 1'b0;
        chk(req, cr_value, model);
        chk({req, " done R7"}, 32'(done), 32'd1);
        @(negedge clk);
        chk("R7 done one cycle", 32'(done), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 reg", cr_value, 32'h0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 illegal", 32'(illegal), 32'd0);
    endtask

    // All eight functions over the four source combinations
    task automatic t_truth();
        int xos[8] = '{257, 449, 193, 225, 33, 289, 129, 417};
        for (int i = 0; i < 8; i++) begin
            for (int c = 0; c < 4; c++) begin
                do_load(32'h0F0F_3C3C ^ (32'(i) << 8));
                // index 2 -> bit 29, index 9 -> bit 22
                model[29] = c[1]; model[22] = c[0];
                do_load(model);
                run_op(i < 4 ? "R3" : "R4", xos[i], 17, 2, 9);
            end
        end
    endtask

    // Index 0 is the MSB, 31 is the LSB
    task automatic t_order();
        do_load(32'h8000_0000);
        run_op("R2 msb", 449, 31, 0, 0);
        chk("R2 lsb set", cr_value, 32'h8000_0001);
        run_op("R5 only dst", 225, 12, 5, 6);
    endtask

    // Destination aliases the sources
    task automatic t_alias();
        do_load(32'h0000_1000);          // index 19 set
        run_op("R6 nand self", 225, 19, 19, 19);
        chk("R6 cleared", cr_value, 32'h0);
        run_op("R6 orc self", 417, 3, 3, 4);
        run_op("R6 xor dst=b", 193, 4, 3, 4);
    endtask

    task automatic t_illegal();
        logic [31:0] keep;
        do_load(32'hA5A5_5A5A);
        keep = cr_value;
        @(negedge clk);
        insn_valid = 1'b1; insn_word = mk(19, 258, 0, 1, 2);
        @(negedge clk);
        insn_valid = 1'b0;
        chk("R8 bad xo reg", cr_value, keep);
        chk("R8 illegal", 32'(illegal), 32'd1);
        chk("R8 no done", 32'(done), 32'd0);
        @(negedge clk);
        chk("R8 one cycle", 32'(illegal), 32'd0);
        insn_valid = 1'b1; insn_word = mk(31, 257, 0, 0, 0);
        @(negedge clk);
        insn_valid = 1'b0;
        chk("R8 bad prim reg", cr_value, keep);
        chk("R8 bad prim flag", 32'(illegal), 32'd1);
    endtask

    task automatic t_load_prio();
        @(negedge clk);
        load_en = 1'b1; load_value = 32'h1234_5678;
        insn_valid = 1'b1; insn_word = mk(19, 449, 0, 31, 31);
        @(negedge clk);
        load_en = 1'b0; insn_valid = 1'b0;
        model = 32'h1234_5678;
        chk("R9 load value", cr_value, model);
        chk("R9 no done", 32'(done), 32'd0);
        insn_valid = 1'b0;
        load_en = 1'b1; insn_word = mk(19, 999, 0, 0, 0); insn_valid = 1'b1;
        load_value = 32'hFFFF_0000;
        @(negedge clk);
        load_en = 1'b0; insn_valid = 1'b0;
        model = 32'hFFFF_0000;
        chk("R9 no illegal", 32'(illegal), 32'd0);
    endtask

    task automatic t_hold();
        insn_word = mk(19, 257, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R10 hold", cr_value, model);
        chk("R10 no flags", 32'({done, illegal}), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_truth();
        t_order();
        t_alias();
        t_illegal();
        t_load_prio();
        t_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule